// File: doc/BRIEF.md
# I2C Register-Access Slave

This block gives an I2C bus master byte-wide access to a bank of sixteen registers that live outside it. SCL and SDA are brought into the system clock domain through a short flop chain. Edges and bus conditions (START, repeated START, STOP) are then found on the synchronised copies. The slave answers to one fixed 7-bit device address. The first byte after a write-addressed frame is taken as a register pointer. Every later byte is either written to the register at the pointer or read from it, and the pointer steps forward after each byte.

The register bank sits behind a plain parallel port. The block presents the current pointer as the address, raises a one-cycle write strobe together with the write data, and samples read data combinationally from the bank. SDA is never driven high. The block only asserts an output enable that pulls the wire low, and the pad and the pull-up are left to the surrounding logic.

A typical read first writes the pointer. It then issues a repeated START with the read address and clocks out as many bytes as needed. The master withholds its acknowledge on the last byte and closes with STOP.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted and after its release, sda_oe_o is 0 and reg_we_o is 0. The pointer is 0 after reset, so a read started without a pointer write returns register 0.
- R2: A first byte of 0xA2 (device address 0x51, direction bit 0 = write) or 0xA3 (direction bit 1 = read) is acknowledged. Any other 7-bit address gets no acknowledge, and every byte after it is ignored until the next START: no acknowledge and no register write.
- R3: A pointer byte in 0x00..0x0F is acknowledged and loaded. A pointer byte above 0x0F gets no acknowledge, and the data bytes that follow get no acknowledge and cause no write.
- R4: Each data byte of a write frame is acknowledged and produces exactly one single-cycle reg_we_o pulse. During that pulse reg_wdata_o equals the byte and reg_addr_o equals the current pointer.
- R5: The pointer advances by one after every data byte, whether written or read, and wraps from 0x0F to 0x00.
- R6: In a read frame the slave sends the register at the pointer MSB first. The byte is captured from the bank at the acknowledge slot and stays fixed while it is shifted out. Further bytes follow for as long as the master acknowledges.
- R7: When the master withholds acknowledge on a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R8: A STOP returns the slave to idle with SDA released. A START or repeated START at any point restarts the address phase, and an unfinished byte is discarded.
- R9: sda_oe_o is only asserted while SCL is low, and it never changes during an SCL high phase of a data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | REG_AW (4) | Register pointer, used for both reads and writes |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 8 | Data for the register write |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The embedded assertions watch several rules on every clock cycle. The write strobe is always one cycle long, lies inside an acknowledge slot and is followed by a pointer step. A START or STOP always leaves the slave in the matching phase with SDA released. The pull-down only ever turns on while the synchronised SCL is low. Address matching, pointer refusal above 0x0F, the wrap from 0x0F to 0x00, the bytes that come back on a read and the release after a master NACK depend on whole transactions. Only the bench's bus-level scenarios, checked against its own copy of the register contents, can show those.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe, sda_pipe;
  logic         scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_o      = scl_pipe[MSB];
  assign sda_o      = sda_pipe[MSB];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA moving while SCL stays high is a bus condition, never data
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h51,
  parameter int unsigned AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [7:0]    reg_wdata_o
);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

  st_e               st;
  logic [BCNT_W-1:0] cnt;
  logic [7:0]        sh, tx, wdata;
  logic [AW-1:0]     ptr;
  logic              rw, mack, oe, we;
  logic              ptr_ok, byte_end;

  assign ptr_ok   = (sh >> AW) == 8'h00;
  assign byte_end = scl_fall_i && (cnt == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      wdata <= '0;
      ptr   <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      oe    <= 1'b0;
      we    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;
      if (start_i) begin
        st  <= ST_ADDR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_s_i};
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  oe <= 1'b1;
                  rw <= sh[0];
                  st <= ST_ADDR_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else if (st == ST_PTR) begin
                if (ptr_ok) begin
                  ptr <= sh[AW-1:0];
                  oe  <= 1'b1;
                  st  <= ST_PTR_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                wdata <= sh;
                we    <= 1'b1;
                oe    <= 1'b1;
                st    <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw) begin
                // capture the byte once; it must not follow later bank changes
                tx  <= rdata_i;
                oe  <= ~rdata_i[7];
                ptr <= ptr + 1'b1;
                cnt <= '0;
                st  <= ST_RDATA;
              end else begin
                oe <= 1'b0;
                st <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              oe <= 1'b0;
              st <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              oe <= 1'b0;
              st <= ST_RDATA_ACK;
            end else if (scl_fall_i) begin
              tx <= {tx[6:0], 1'b0};
              oe <= ~tx[6];
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                tx  <= rdata_i;
                oe  <= ~rdata_i[7];
                ptr <= ptr + 1'b1;
                cnt <= '0;
                st  <= ST_RDATA;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe;
  assign reg_addr_o  = ptr;
  assign reg_we_o    = we;
  assign reg_wdata_o = wdata;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R4
  AST_WE_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (st == ST_WDATA_ACK) && sda_oe_o); // R4
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> reg_addr_o == AW'($past(reg_addr_o) + 1'b1)); // R5
  AST_START_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st == ST_ADDR) && !sda_oe_o); // R8
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (st == ST_IDLE) && !sda_oe_o); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s_i); // R9
  AST_NACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT) |-> !sda_oe_o); // R7
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h51,
  parameter int unsigned REG_AW      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_rs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_rs_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .rdata_i     (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_we_o    (reg_we_o),
    .reg_wdata_o (reg_wdata_o)
  );
endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int Q = 10;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [3:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] bank [16];
  logic [7:0] exp_bank [16];

  int n_chk = 0;
  int n_err = 0;
  int we_cnt = 0;
  int oe_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_we_o    (reg_we),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'hA0 ^ 8'(i);
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = bank[reg_addr];

  logic scl_prev = 1'b1;
  logic oe_prev  = 1'b0;
  always @(negedge clk) begin
    if (reg_we) we_cnt++;
    if (scl_m && scl_prev && (sda_oe != oe_prev)) oe_viol++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b0; quarter();
    scl_m = 1'b0; quarter();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b1; quarter();
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; quarter();
      scl_m = 1'b1; quarter(); quarter();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    ack = ~sda_bus;
    quarter();
    scl_m = 1'b0; quarter();
  endtask

  task automatic rb(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      quarter();
      scl_m = 1'b1; quarter();
      b[i] = sda_bus;
      quarter();
      scl_m = 1'b0;
    end
    quarter();
    sda_m = ~mack; quarter();
    scl_m = 1'b1; quarter(); quarter();
    scl_m = 1'b0;
    sda_m = 1'b1; quarter();
  endtask

  // {pointer, data}
  localparam logic [15:0] VEC [6] = '{16'h00_5A, 16'h07_C3, 16'h0F_81,
                                      16'h1F_EE, 16'h03_3C, 16'h80_12};

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    bit ack;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 16; i++) exp_bank[i] = 8'hA0 ^ 8'(i);
    repeat (3) @(negedge clk);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R1 in reset", {sda_oe, reg_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R1 after reset", {sda_oe, reg_we}, 0);

    // R1: read without pointer write starts at register 0
    bus_start(); wb(8'hA3, ack);
    check(ack, "R2 read address ack", ack, 1);
    rb(1'b0, d); bus_stop();
    check(d == exp_bank[0], "R1 reset pointer", d, exp_bank[0]);

    foreach (VEC[k]) begin
      logic [7:0] p, v;
      bit ok;
      p = VEC[k][15:8];
      v = VEC[k][7:0];
      ok = (p < 8'h10);
      w0 = we_cnt;
      bus_start(); wb(8'hA2, ack);
      check(ack, "R2 write address ack", ack, 1);
      wb(p, ack);
      check(ack == ok, "R3 pointer ack", ack, ok);
      wb(v, ack);
      check(ack == ok, "R4 data ack", ack, ok);
      bus_stop();
      check(we_cnt - w0 == (ok ? 1 : 0), "R3 R4 write count", we_cnt - w0, ok);
      if (ok) begin
        exp_bank[p[3:0]] = v;
        bus_start(); wb(8'hA2, ack); wb(p, ack);
        bus_start(); wb(8'hA3, ack); rb(1'b0, d); bus_stop();
        check(d == v, "R6 readback", d, v);
      end
    end

    // R5: multi-byte write wrapping past 0x0F
    w0 = we_cnt;
    bus_start(); wb(8'hA2, ack); wb(8'h0E, ack);
    wb(8'h11, ack); wb(8'h22, ack); wb(8'h33, ack);
    check(ack, "R4 third data ack", ack, 1);
    bus_stop();
    exp_bank[14] = 8'h11; exp_bank[15] = 8'h22; exp_bank[0] = 8'h33;
    check(we_cnt - w0 == 3, "R4 burst strobes", we_cnt - w0, 3);
    // R6 R5: burst read with repeated START, wrapping
    bus_start(); wb(8'hA2, ack); wb(8'h0E, ack);
    bus_start(); wb(8'hA3, ack);
    rb(1'b1, d); check(d == exp_bank[14], "R6 burst byte0", d, exp_bank[14]);
    rb(1'b1, d); check(d == exp_bank[15], "R5 burst byte1", d, exp_bank[15]);
    rb(1'b0, d); check(d == exp_bank[0], "R5 wrap byte2", d, exp_bank[0]);
    // R7: after NACK the slave stays off the bus
    check(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
    rb(1'b0, d);
    check(d == 8'hFF, "R7 quiet after nack", d, 8'hFF);
    bus_stop();

    // R2: foreign address, following bytes ignored
    w0 = we_cnt;
    bus_start(); wb(8'hA4, ack);
    check(!ack, "R2 foreign address nack", ack, 0);
    wb(8'h03, ack);
    check(!ack, "R2 ignored pointer", ack, 0);
    wb(8'h99, ack);
    check(!ack, "R2 ignored data", ack, 0);
    bus_stop();
    check(we_cnt == w0, "R2 no write", we_cnt - w0, 0);

    // R8: repeated START abandons the first frame
    bus_start(); wb(8'hA2, ack); wb(8'h05, ack);
    bus_start(); wb(8'hA2, ack); wb(8'h06, ack); wb(8'h77, ack);
    bus_stop();
    exp_bank[6] = 8'h77;
    bus_start(); wb(8'hA2, ack); wb(8'h05, ack);
    bus_start(); wb(8'hA3, ack);
    rb(1'b1, d); check(d == exp_bank[5], "R8 reg5 untouched", d, exp_bank[5]);
    rb(1'b0, d); check(d == 8'h77, "R8 reg6 written", d, 8'h77);
    bus_stop();
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);

    check(oe_viol == 0, "R9 oe stable while SCL high", oe_viol, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule